// File: doc/BRIEF.md
# Integer Execute Stage for Add, Shift and Immediate Operations

This block is the execute step for a small group of 32-bit integer instructions: register add, logical left shift, logical right shift, add-immediate and and-immediate. Each cycle it takes one instruction word together with the values already read for its two source registers. It decodes the instruction fields itself, works out the result and the signed-overflow condition, and chooses which register is written and whether the write happens.

The register file stays outside the block. The surrounding pipeline feeds in the source values and uses the registered outputs one clock later to update the register file. An instruction that overflows, targets register 0, or is not in the supported set produces no write.

Top module: `int_exec_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero: destination index 0, write enable 0, result 0, overflow 0.
- R2: The outputs show the instruction and operands sampled at the previous rising clock edge. The block has exactly one cycle of latency.
- R3: Opcode bits 31:26 equal to 0 with function bits 5:0 equal to 6'h20 is a register add. Its result is rs plus rt, wrapping modulo 2^32, and its destination is bits 15:11.
- R4: A register add whose two operands have the same sign bit while the sum has the other sign bit raises overflow and clears the write enable.
- R5: Opcode 6'h08 adds rs to bits 15:0 sign-extended to 32 bits. Its destination is bits 20:16, and it follows the same overflow rule as R4.
- R6: Opcode 6'h0C gives rs AND bits 15:0 zero-extended, with the destination at bits 20:16. It never raises overflow, and result bits 31:16 are always zero.
- R7: Opcode 0 with function 6'h00 shifts the rt value left by the amount in bits 10:6. Vacated low bits are filled with zeros and the destination is bits 15:11.
- R8: Opcode 0 with function 6'h02 shifts the rt value right by bits 10:6 and fills the vacated upper bits with zeros.
- R9: When the destination index is 0, the write enable is 0. The result is still produced.
- R10: An instruction outside the supported set gives write enable 0, overflow 0 and result 0. This covers any other opcode, any other function code, a shift with bits 25:21 not equal to 0, and an add with bits 10:6 not equal to 0. The destination index is still bits 15:11 when the opcode is 0 and bits 20:16 otherwise.
- R11: The write enable is 1 exactly when the instruction is supported, the destination is not 0, and there is no overflow. Overflow and write enable are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| dst_idx_o | output | 5 | Index of the destination register |
| wr_en_o | output | 1 | Register write enable |
| result_o | output | 32 | Computed result |
| ovf_o | output | 1 | Signed overflow exception |

## Verification
The bench builds the block with its default parameters: 32-bit data, 5-bit register indices, a 5-bit shift amount and a 16-bit immediate. At these settings the exact overflow boundaries 0x7FFFFFFF and 0x80000000 can be reached with the real immediate range, and every shift distance from 0 to 31 can be produced. This lets the directed cases hit both ends of the sign-extended immediate and the largest shifts. A behavioural model in the bench uses wide integer arithmetic and checks the outputs every cycle, both for the directed cases and for a long series of randomly chosen encodings.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;

    localparam logic [FN_W-1:0]  FN_SLL    = 6'h00;
    localparam logic [FN_W-1:0]  FN_SRL    = 6'h02;
    localparam logic [FN_W-1:0]  FN_ADD    = 6'h20;

    typedef enum logic [2:0] {
        XOP_NONE,
        XOP_ADD,
        XOP_SLL,
        XOP_SRL,
        XOP_ADDI,
        XOP_ANDI
    } xop_e;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
    import int_exec_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int SHAMT_W = 5,
    parameter int IMM_W   = 16
) (
    input  logic [INSTR_W-1:0] instr_i,
    output xop_e               op_o,
    output logic [REG_AW-1:0]  dst_o,
    output logic [SHAMT_W-1:0] shamt_o,
    output logic [IMM_W-1:0]   imm_o
);

    localparam int FN_LO  = 0;
    localparam int SH_LO  = FN_LO + FN_W;
    localparam int RD_LO  = SH_LO + SHAMT_W;
    localparam int RT_LO  = RD_LO + REG_AW;
    localparam int RS_LO  = RT_LO + REG_AW;
    localparam int OPC_LO = INSTR_W - OPC_W;

    logic [OPC_W-1:0]   opc;
    logic [FN_W-1:0]    fn;
    logic [REG_AW-1:0]  rs_f;
    logic [REG_AW-1:0]  rt_f;
    logic [REG_AW-1:0]  rd_f;
    logic [SHAMT_W-1:0] sh_f;

    assign opc  = instr_i[OPC_LO +: OPC_W];
    assign fn   = instr_i[FN_LO +: FN_W];
    assign rs_f = instr_i[RS_LO +: REG_AW];
    assign rt_f = instr_i[RT_LO +: REG_AW];
    assign rd_f = instr_i[RD_LO +: REG_AW];
    assign sh_f = instr_i[SH_LO +: SHAMT_W];

    assign shamt_o = sh_f;
    assign imm_o   = instr_i[IMM_W-1:0];

    always_comb begin
        op_o  = XOP_NONE;
        dst_o = rt_f;
        if (opc == OPC_RTYPE) begin
            dst_o = rd_f;
            unique case (fn)
                FN_ADD:  op_o = (sh_f == '0) ? XOP_ADD : XOP_NONE;
                FN_SLL:  op_o = (rs_f == '0) ? XOP_SLL : XOP_NONE;
                FN_SRL:  op_o = (rs_f == '0) ? XOP_SRL : XOP_NONE;
                default: op_o = XOP_NONE;
            endcase
        end else if (opc == OPC_ADDI) begin
            op_o = XOP_ADDI;
        end else if (opc == OPC_ANDI) begin
            op_o = XOP_ANDI;
        end
    end

endmodule

// File: rtl/exec_shift.sv
module exec_shift #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5
) (
    input  logic               left_i,
    input  logic [DATA_W-1:0]  val_i,
    input  logic [SHAMT_W-1:0] amt_i,
    output logic [DATA_W-1:0]  val_o
);

    logic [DATA_W-1:0] stage [SHAMT_W+1];

    assign stage[0] = val_i;

    for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
        localparam int DIST = 1 << g;
        logic [DATA_W-1:0] moved;
        always_comb begin
            if (left_i) moved = stage[g] << DIST;
            else        moved = stage[g] >> DIST;
        end
        assign stage[g+1] = amt_i[g] ? moved : stage[g];
    end

    assign val_o = stage[SHAMT_W];

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import int_exec_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5,
    parameter int IMM_W   = 16
) (
    input  xop_e               op_i,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [IMM_W-1:0]   imm_i,
    output logic [DATA_W-1:0]  res_o,
    output logic               ovf_o,
    output logic               known_o
);

    localparam int EXT_W = DATA_W - IMM_W;
    localparam int MSB   = DATA_W - 1;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W-1:0] sum;
    logic              sum_ovf;
    logic [DATA_W-1:0] shifted;

    assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign imm_zx = {{EXT_W{1'b0}}, imm_i};
    assign add_b  = (op_i == XOP_ADDI) ? imm_sx : b_i;
    assign sum    = a_i + add_b;
    assign sum_ovf = (a_i[MSB] == add_b[MSB]) && (sum[MSB] != a_i[MSB]);

    exec_shift #(
        .DATA_W (DATA_W),
        .SHAMT_W(SHAMT_W)
    ) u_shift (
        .left_i(op_i == XOP_SLL),
        .val_i (b_i),
        .amt_i (shamt_i),
        .val_o (shifted)
    );

    always_comb begin
        res_o   = '0;
        ovf_o   = 1'b0;
        known_o = 1'b1;
        unique case (op_i)
            XOP_ADD, XOP_ADDI: begin
                res_o = sum;
                ovf_o = sum_ovf;
            end
            XOP_ANDI:          res_o = a_i & imm_zx;
            XOP_SLL, XOP_SRL:  res_o = shifted;
            default:           known_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
    import int_exec_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_AW  = 5,
    parameter int SHAMT_W = 5,
    parameter int IMM_W   = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [31:0]        instr_i,
    input  logic [DATA_W-1:0]  rs_val_i,
    input  logic [DATA_W-1:0]  rt_val_i,
    output logic [REG_AW-1:0]  dst_idx_o,
    output logic               wr_en_o,
    output logic [DATA_W-1:0]  result_o,
    output logic               ovf_o
);

    localparam int OPC_LO = INSTR_W - OPC_W;

    typedef struct packed {
        logic [REG_AW-1:0] dst;
        logic              we;
        logic [DATA_W-1:0] res;
        logic              ovf;
    } stage_t;

    xop_e               op;
    logic [REG_AW-1:0]  dst;
    logic [SHAMT_W-1:0] shamt;
    logic [IMM_W-1:0]   imm;
    logic [DATA_W-1:0]  alu_res;
    logic               alu_ovf;
    logic               alu_known;

    stage_t out_d;
    stage_t out_q;

    exec_decode #(
        .REG_AW (REG_AW),
        .SHAMT_W(SHAMT_W),
        .IMM_W  (IMM_W)
    ) u_decode (
        .instr_i(instr_i),
        .op_o   (op),
        .dst_o  (dst),
        .shamt_o(shamt),
        .imm_o  (imm)
    );

    exec_alu #(
        .DATA_W (DATA_W),
        .SHAMT_W(SHAMT_W),
        .IMM_W  (IMM_W)
    ) u_alu (
        .op_i   (op),
        .a_i    (rs_val_i),
        .b_i    (rt_val_i),
        .shamt_i(shamt),
        .imm_i  (imm),
        .res_o  (alu_res),
        .ovf_o  (alu_ovf),
        .known_o(alu_known)
    );

    always_comb begin
        out_d     = '0;
        out_d.dst = dst;
        out_d.res = alu_res;
        out_d.ovf = alu_ovf;
        out_d.we  = alu_known && !alu_ovf && (dst != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign dst_idx_o = out_q.dst;
    assign wr_en_o   = out_q.we;
    assign result_o  = out_q.res;
    assign ovf_o     = out_q.ovf;

    AST_OVF_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> !wr_en_o); // R4

    AST_ZERO_DST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dst_idx_o == '0) |-> !wr_en_o); // R9

    AST_ANDI_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[OPC_LO +: OPC_W] == OPC_ANDI) |=> (!ovf_o && result_o[DATA_W-1:IMM_W] == '0)); // R6

    AST_UNKNOWN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == XOP_NONE) |=> (!wr_en_o && !ovf_o && result_o == '0)); // R10

    AST_SRL_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == XOP_SRL && shamt != '0) |=> !result_o[DATA_W-1]); // R8

endmodule

// File: tb/int_exec_stage_test.sv
module int_exec_stage_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_v = '0;
    logic [31:0] rt_v = '0;
    logic [4:0]  dst_idx;
    logic        wr_en;
    logic [31:0] result;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    int_exec_stage uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .instr_i  (instr),
        .rs_val_i (rs_v),
        .rt_val_i (rt_v),
        .dst_idx_o(dst_idx),
        .wr_en_o  (wr_en),
        .result_o (result),
        .ovf_o    (ovf)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int opc, int rs, int rt, int imm);
        return {6'(opc), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         output logic [4:0] d, output bit we, output logic [31:0] r,
                         output bit ov);
        int    opc = int'(ins[31:26]);
        int    fn  = int'(ins[5:0]);
        int    sh  = int'(ins[10:6]);
        bit    ok  = 1'b0;
        longint s;
        r  = '0;
        ov = 1'b0;
        if (opc == 0) begin
            d = ins[15:11];
            if (fn == 32 && sh == 0) begin
                ok = 1'b1;
                s  = longint'($signed(a)) + longint'($signed(b));
                r  = a + b;
                ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end else if (fn == 0 && ins[25:21] == 0) begin
                ok = 1'b1;
                r  = b << sh;
            end else if (fn == 2 && ins[25:21] == 0) begin
                ok = 1'b1;
                r  = b >> sh;
            end
        end else begin
            d = ins[20:16];
            if (opc == 8) begin
                ok = 1'b1;
                s  = longint'($signed(a)) + longint'($signed(ins[15:0]));
                r  = a + {{16{ins[15]}}, ins[15:0]};
                ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end else if (opc == 12) begin
                ok = 1'b1;
                r  = a & {16'h0, ins[15:0]};
            end
        end
        we = ok && !ov && (d != 0);
    endtask

    task automatic compare(string tag, logic [4:0] ed, bit ewe, logic [31:0] er, bit eov);
        checks++;
        if (dst_idx !== ed || wr_en !== ewe || result !== er || ovf !== eov) begin
            errors++;
            $display("FAIL %s: actual dst=%0d we=%0b res=%h ovf=%0b expected dst=%0d we=%0b res=%h ovf=%0b",
                     tag, dst_idx, wr_en, result, ovf, ed, ewe, er, eov);
        end
    endtask

    task automatic run(string tag, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
        logic [4:0]  ed;
        bit          ewe;
        logic [31:0] er;
        bit          eov;
        @(negedge clk);
        instr = ins;
        rs_v  = a;
        rt_v  = b;
        model(ins, a, b, ed, ewe, er, eov);
        @(negedge clk);
        compare(tag, ed, ewe, er, eov);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        instr = enc_r(1, 2, 3, 0, 32);
        rs_v  = 32'h1234;
        rt_v  = 32'h1;
        repeat (3) @(negedge clk);
        compare("R1 during reset", 5'd0, 1'b0, 32'h0, 1'b0);
        rst_n = 1'b1;
        // first edge after release loads the pending add
        @(negedge clk);
        compare("R2 first load", 5'd3, 1'b1, 32'h1235, 1'b0);

        run("R3 add",            enc_r(1, 2, 3, 0, 32), 32'd5, 32'd7);
        run("R3 add wrap",       enc_r(4, 5, 6, 0, 32), 32'hFFFF_FFFF, 32'h1);
        run("R4 add ovf pos",    enc_r(4, 5, 7, 0, 32), 32'h7FFF_FFFF, 32'h1);
        run("R4 add ovf neg",    enc_r(4, 5, 7, 0, 32), 32'h8000_0000, 32'hFFFF_FFFF);
        run("R4 add mixed sign", enc_r(4, 5, 7, 0, 32), 32'h8000_0000, 32'h7FFF_FFFF);
        run("R5 addi neg imm",   enc_i(8, 1, 9, 16'hFFFF), 32'd5, 32'hDEAD_BEEF);
        run("R5 addi ovf",       enc_i(8, 1, 9, 16'h7FFF), 32'h7FFF_FFF0, 32'h0);
        run("R5 addi ovf neg",   enc_i(8, 1, 9, 16'h8000), 32'h8000_0000, 32'h0);
        run("R6 andi zext",      enc_i(12, 1, 10, 16'h8001), 32'hFFFF_FFFF, 32'h0);
        run("R7 sll 31",         enc_r(0, 2, 11, 31, 0), 32'h0, 32'h1);
        run("R7 sll 0",          enc_r(0, 2, 11, 0, 0), 32'h0, 32'hA5A5_5A5A);
        run("R8 srl 31",         enc_r(0, 2, 12, 31, 2), 32'h0, 32'h8000_0000);
        run("R8 srl 4",          enc_r(0, 2, 12, 4, 2), 32'h0, 32'hF000_0000);
        run("R9 add to r0",      enc_r(1, 2, 0, 0, 32), 32'd3, 32'd4);
        run("R9 addi to r0",     enc_i(8, 1, 0, 16'h0010), 32'd3, 32'd0);
        run("R10 add shamt set", enc_r(1, 2, 3, 5, 32), 32'd3, 32'd4);
        run("R10 sll rs set",    enc_r(7, 2, 3, 1, 0), 32'd3, 32'd4);
        run("R10 bad opcode",    enc_i(35, 1, 3, 16'h0004), 32'd3, 32'd4);
        run("R10 bad funct",     enc_r(1, 2, 3, 0, 33), 32'd3, 32'd4);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ins;
            logic [31:0] a;
            logic [31:0] b;
            int          pick = int'($urandom_range(0, 6));
            a = $urandom();
            b = $urandom();
            if (i % 4 == 0) a = {a[31], {31{~a[31]}}};
            case (pick)
                0: ins = enc_r(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                               int'($urandom_range(0, 31)), 0, 32);
                1: ins = enc_i(8, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                               int'($urandom_range(0, 65535)));
                2: ins = enc_i(12, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                               int'($urandom_range(0, 65535)));
                3: ins = enc_r(0, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                               int'($urandom_range(0, 31)), 0);
                4: ins = enc_r(0, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                               int'($urandom_range(0, 31)), 2);
                default: ins = $urandom();
            endcase
            run("R11 random", ins, a, b);
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        compare("R1 reset again", 5'd0, 1'b0, 32'h0, 1'b0);

        done = 1'b1;
        summary();
    end

endmodule